// File: doc/BRIEF.md
# Memory Sum-of-Products Engine

This block computes a sum of products over two arrays held in byte-addressed memory, running the whole loop on its own once started. The caller supplies a pointer to the multiplicand array, a pointer to the multiplier array, an element count, a starting accumulator value and an element size (8-bit or 16-bit). Each pass reads one element through each pointer, forms their signed product, adds it to the accumulator, steps both pointers by the element size and counts the loop counter down by one.

The loop ends when the counter reaches zero or as soon as an accumulation overflows in two's complement, in which case an overflow flag is raised. When the engine stops it shows the final accumulator, both pointers and the remaining count. An interrupt request that arrives while the loop runs is held back and only passed on once the operation has finished. Operand memory is reached through a simple byte read port with one cycle of latency.

Top module: `sop_engine`

## Requirements
- R1: After reset `busy`, `done`, `ovf_out`, `mem_rd` and `irq_pend` are low and `acc_out`, `ptr_a_out`, `ptr_b_out` and `count_out` are zero.
- R2: Operands are read one byte at a time: a byte requested with `mem_rd` high at `mem_addr` in one cycle is taken from `mem_rdata` in the next cycle. The multiplicand comes from the address in pointer A and the multiplier from pointer B. A 16-bit element is little-endian: low byte at the pointer, high byte at pointer+1. `mem_rd` is only high while `busy` is high.
- R3: With `word_mode`=1 both operands are signed 16-bit values, and their signed product is added to the full 32-bit accumulator.
- R4: With `word_mode`=0 both operands are signed 8-bit values, and the product is added to `acc[15:0]` as a 16-bit signed accumulator; `acc_out[31:16]` keeps the value of `acc_in[31:16]` for the whole run.
- R5: Each iteration advances both pointers by 2 (word) or 1 (byte) and lowers the count by 1. When the count reaches zero the engine stops and raises `done` for exactly one cycle with `count_out`=0.
- R6: A start with `count_in`=0 ends with `done` and no memory read; the accumulator and both pointers keep their start values and `ovf_out` is 0.
- R7: If an accumulation overflows in two's complement (32-bit in word mode, 16-bit in byte mode), the wrapped sum is stored, that iteration's pointer and count updates still happen, `ovf_out` goes high and the engine stops, raising `done` in the same cycle. `ovf_out` is cleared by the next start.
- R8: While `busy` is high `irq_pend` stays low. A request seen on `irq_req` while busy, even a one-cycle pulse, is remembered and shown on `irq_pend` in the `done` cycle.
- R9: While idle, `irq_pend` follows `irq_req` in the same cycle.
- R10: A `start` pulse while the engine is running is ignored: the running operation finishes with its own results and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| word_mode | input | 1 | 1 = 16-bit elements, 0 = 8-bit elements |
| ptr_a_in | input | ADDR_W | Start address of the multiplicand array |
| ptr_b_in | input | ADDR_W | Start address of the multiplier array |
| count_in | input | CNT_W | Number of products to accumulate |
| acc_in | input | 32 | Starting accumulator value |
| irq_req | input | 1 | Incoming interrupt request |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | ADDR_W | Byte read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the operation ends |
| acc_out | output | 32 | Accumulator |
| ptr_a_out | output | ADDR_W | Current multiplicand pointer |
| ptr_b_out | output | ADDR_W | Current multiplier pointer |
| count_out | output | CNT_W | Remaining count |
| ovf_out | output | 1 | Overflow flag of the last operation |
| irq_pend | output | 1 | Interrupt request passed on to the system |

## Verification
A wrong fetch slot, a wrong byte order or a sign error in the operand path shows at the ports as a wrong `acc_out` in the `done` cycle of the same operation, while a wrong pointer step or counter update shows in `ptr_a_out`, `ptr_b_out` and `count_out` at that same cycle. An overflow check that misses or fires wrongly changes the stopping iteration, so the count, the pointers and `ovf_out` all differ at `done`. A broken interrupt hold shows within one cycle of the request as `irq_pend` rising while `busy` is high, or as a missing `irq_pend` in the `done` cycle.

// File: rtl/sop_engine.sv
module sop_engine #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] ptr_a_in,
  input  logic [ADDR_W-1:0] ptr_b_in,
  input  logic [CNT_W-1:0]  count_in,
  input  logic [31:0]       acc_in,
  input  logic              irq_req,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [31:0]       acc_out,
  output logic [ADDR_W-1:0] ptr_a_out,
  output logic [ADDR_W-1:0] ptr_b_out,
  output logic [CNT_W-1:0]  count_out,
  output logic              ovf_out,
  output logic              irq_pend
);

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_FETCH, S_CAP, S_MAC, S_FIN} state_t;

  state_t            state;
  logic              word_q;
  logic [ADDR_W-1:0] pa, pb;
  logic [CNT_W-1:0]  cnt;
  logic [31:0]       acc;
  logic              ovf;
  logic [1:0]        slot, slot_q;
  logic              rd_q;
  logic [7:0]        opnd [4];
  logic              irq_seen;

  logic signed [15:0] a_s, b_s;
  logic signed [31:0] prod;
  logic [32:0]        sum_w;
  logic [16:0]        sum_b;
  logic               ovf_now;
  logic [31:0]        new_acc;
  logic [ADDR_W-1:0]  step;
  logic               last_slot;

  assign a_s  = word_q ? {opnd[1], opnd[0]} : {{8{opnd[0][7]}}, opnd[0]};
  assign b_s  = word_q ? {opnd[3], opnd[2]} : {{8{opnd[2][7]}}, opnd[2]};
  assign prod = a_s * b_s;

  assign sum_w = {acc[31], acc} + {prod[31], prod};
  assign sum_b = {acc[15], acc[15:0]} + {prod[15], prod[15:0]};

  assign ovf_now = word_q ? (sum_w[32] != sum_w[31]) : (sum_b[16] != sum_b[15]);
  assign new_acc = word_q ? sum_w[31:0] : {acc[31:16], sum_b[15:0]};
  assign step    = word_q ? ADDR_W'(2) : ADDR_W'(1);

  assign last_slot = word_q ? (slot == 2'd3) : (slot == 2'd2);

  assign mem_rd   = (state == S_FETCH);
  assign mem_addr = (slot[1] ? pb : pa) + ADDR_W'(slot[0]);

  assign busy      = (state != S_IDLE) && (state != S_FIN);
  assign done      = (state == S_FIN);
  assign acc_out   = acc;
  assign ptr_a_out = pa;
  assign ptr_b_out = pb;
  assign count_out = cnt;
  assign ovf_out   = ovf;
  assign irq_pend  = !busy && (irq_req || irq_seen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      word_q   <= 1'b0;
      pa       <= '0;
      pb       <= '0;
      cnt      <= '0;
      acc      <= '0;
      ovf      <= 1'b0;
      slot     <= '0;
      slot_q   <= '0;
      rd_q     <= 1'b0;
      irq_seen <= 1'b0;
      for (int i = 0; i < 4; i++) opnd[i] <= '0;
    end else begin
      rd_q   <= mem_rd;
      slot_q <= slot;
      if (rd_q) opnd[slot_q] <= mem_rdata;

      if (busy && irq_req)   irq_seen <= 1'b1;
      else if (state == S_FIN) irq_seen <= 1'b0;

      case (state)
        S_IDLE: if (start) begin
          word_q <= word_mode;
          pa     <= ptr_a_in;
          pb     <= ptr_b_in;
          cnt    <= count_in;
          acc    <= acc_in;
          ovf    <= 1'b0;
          state  <= S_CHECK;
        end
        S_CHECK: begin
          slot  <= '0;
          state <= (cnt == '0) ? S_FIN : S_FETCH;
        end
        S_FETCH: begin
          slot <= slot + (word_q ? 2'd1 : 2'd2);
          if (last_slot) state <= S_CAP;
        end
        S_CAP: state <= S_MAC;
        S_MAC: begin
          acc   <= new_acc;
          pa    <= pa + step;
          pb    <= pb + step;
          cnt   <= cnt - 1'b1;
          ovf   <= ovf_now;
          state <= ovf_now ? S_FIN : S_CHECK;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sop_engine_chk.sv
module sop_engine_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             mem_rd,
  input logic             ovf_out,
  input logic             irq_pend,
  input logic [CNT_W-1:0] count_out,
  input logic [15:0]      acc_hi,
  input logic             word_q
);

  assert_single_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_count_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ovf_out) |-> (count_out == '0));

  assert_read_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy);

  assert_irq_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq_pend);

  assert_ovf_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_out) |-> done);

  assert_upper_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !word_q) |-> $stable(acc_hi));

endmodule

bind sop_engine sop_engine_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .mem_rd   (mem_rd),
  .ovf_out  (ovf_out),
  .irq_pend (irq_pend),
  .count_out(count_out),
  .acc_hi   (acc_out[31:16]),
  .word_q   (word_q)
);

// File: tb/sop_engine_tb_top.sv
module sop_engine_tb_top;
  localparam int AW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, word_mode = 1'b0, irq_req = 1'b0;
  logic [AW-1:0] ptr_a_in = '0, ptr_b_in = '0;
  logic [CW-1:0] count_in = '0;
  logic [31:0]   acc_in = '0;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata = '0;
  logic          busy, done, ovf_out, irq_pend;
  logic [31:0]   acc_out;
  logic [AW-1:0] ptr_a_out, ptr_b_out;
  logic [CW-1:0] count_out;

  logic [7:0] mem [256];

  int n_checks = 0;
  int n_fails  = 0;

  typedef struct {
    logic [31:0]   acc;
    logic [AW-1:0] pa, pb;
    logic [CW-1:0] cnt;
    logic          ovf;
    string         rq;
  } exp_t;

  exp_t q[$];

  always #5 clk = ~clk;

  sop_engine #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .word_mode(word_mode),
    .ptr_a_in(ptr_a_in), .ptr_b_in(ptr_b_in), .count_in(count_in),
    .acc_in(acc_in), .irq_req(irq_req), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .acc_out(acc_out),
    .ptr_a_out(ptr_a_out), .ptr_b_out(ptr_b_out), .count_out(count_out),
    .ovf_out(ovf_out), .irq_pend(irq_pend)
  );

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, expv);
    end
  endtask

  function automatic exp_t model(input bit w, input logic [AW-1:0] pa,
                                 input logic [AW-1:0] pb, input logic [CW-1:0] cnt,
                                 input logic [31:0] acc, input string rq);
    exp_t e;
    e.ovf = 1'b0;
    while (cnt != 0) begin
      longint av, bv, s;
      if (w) begin
        av = longint'($signed({mem[(pa + 1) & 8'hff], mem[pa & 8'hff]}));
        bv = longint'($signed({mem[(pb + 1) & 8'hff], mem[pb & 8'hff]}));
        s  = longint'($signed(acc)) + av * bv;
        e.ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        acc = s[31:0];
      end else begin
        av = longint'($signed(mem[pa & 8'hff]));
        bv = longint'($signed(mem[pb & 8'hff]));
        s  = longint'($signed(acc[15:0])) + av * bv;
        e.ovf = (s > 32767) || (s < -32768);
        acc[15:0] = s[15:0];
      end
      pa  = pa + (w ? 2 : 1);
      pb  = pb + (w ? 2 : 1);
      cnt = cnt - 1;
      if (e.ovf) break;
    end
    e.acc = acc; e.pa = pa; e.pb = pb; e.cnt = cnt; e.rq = rq;
    return e;
  endfunction

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        check(1'b0, "R10", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(acc_out == e.acc, e.rq, "acc_out", acc_out, e.acc);
        check(ptr_a_out == e.pa, e.rq, "ptr_a_out", ptr_a_out, e.pa);
        check(ptr_b_out == e.pb, e.rq, "ptr_b_out", ptr_b_out, e.pb);
        check(count_out == e.cnt, e.rq, "count_out", count_out, e.cnt);
        check(ovf_out == e.ovf, e.rq, "ovf_out", ovf_out, e.ovf);
      end
    end
  end

  task automatic launch(input bit w, input logic [AW-1:0] pa, input logic [AW-1:0] pb,
                        input logic [CW-1:0] cnt, input logic [31:0] acc, input string rq);
    q.push_back(model(w, pa, pb, cnt, acc, rq));
    @(negedge clk);
    word_mode = w; ptr_a_in = pa; ptr_b_in = pb; count_in = cnt; acc_in = acc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_op();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic go(input bit w, input logic [AW-1:0] pa, input logic [AW-1:0] pb,
                    input logic [CW-1:0] cnt, input logic [31:0] acc, input string rq);
    launch(w, pa, pb, cnt, acc, rq);
    finish_op();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R5", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    bit saw_rd, bad_irq;
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
    mem[8'hC0] = 8'hFF; mem[8'hC1] = 8'h7F;
    mem[8'hC2] = 8'hFF; mem[8'hC3] = 8'h7F;
    mem[8'hC8] = 8'h7F; mem[8'hC9] = 8'h7F;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !mem_rd, "R1", "busy/done/mem_rd", {busy, done, mem_rd}, 0);
    check(!ovf_out && !irq_pend, "R1", "ovf/irq_pend", {ovf_out, irq_pend}, 0);
    check(acc_out == 0 && count_out == 0, "R1", "acc/count", acc_out, 0);
    check(ptr_a_out == 0 && ptr_b_out == 0, "R1", "pointers", ptr_a_out, 0);

    // R2 R3 R5 word mode, several patterns
    go(1'b1, 16'h0010, 16'h0040, 16'd8, 32'h0000_0000, "R3");
    go(1'b1, 16'h0021, 16'h0057, 16'd5, 32'hFFF0_1234, "R2");
    go(1'b1, 16'h0030, 16'h0031, 16'd1, 32'h0000_0100, "R5");

    // R4 byte mode, upper half kept
    go(1'b0, 16'h0080, 16'h00A0, 16'd12, 32'hABCD_0010, "R4");
    go(1'b0, 16'h0003, 16'h00F0, 16'd7, 32'h5555_FF00, "R4");

    // R6 zero count: no reads
    saw_rd = 1'b0;
    launch(1'b1, 16'h0011, 16'h0022, 16'd0, 32'h1357_9BDF, "R6");
    while (q.size() != 0) begin
      if (mem_rd) saw_rd = 1'b1;
      @(negedge clk);
    end
    check(!saw_rd, "R6", "memory read on zero count", saw_rd, 0);

    // R7 overflow, word and byte
    go(1'b1, 16'h00C0, 16'h00C2, 16'd3, 32'h7FFF_0000, "R7");
    go(1'b0, 16'h00C8, 16'h00C9, 16'd5, 32'h1234_7F00, "R7");
    go(1'b1, 16'h0010, 16'h0012, 16'd2, 32'h0000_0001, "R7");
    check(!ovf_out, "R7", "ovf cleared by next start", ovf_out, 0);

    // R8 interrupt held while busy
    bad_irq = 1'b0;
    launch(1'b1, 16'h0050, 16'h0060, 16'd4, 32'h0, "R8");
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    while (!done) begin
      if (busy && irq_pend) bad_irq = 1'b1;
      @(negedge clk);
    end
    check(!bad_irq, "R8", "irq_pend while busy", bad_irq, 0);
    check(irq_pend, "R8", "irq_pend at done", irq_pend, 1);
    @(negedge clk);
    check(!irq_pend, "R8", "irq_pend after done, request gone", irq_pend, 0);

    // R9 idle pass-through
    irq_req = 1'b1;
    #1;
    check(irq_pend, "R9", "idle irq pass-through", irq_pend, 1);
    @(negedge clk);
    irq_req = 1'b0;
    #1;
    check(!irq_pend, "R9", "idle irq release", irq_pend, 0);

    // R10 start while busy ignored
    launch(1'b1, 16'h0070, 16'h0090, 16'd3, 32'h0000_0042, "R10");
    @(negedge clk);
    word_mode = 1'b0; ptr_a_in = 16'h0001; ptr_b_in = 16'h0002;
    count_in = 16'd9; acc_in = 32'hDEAD_BEEF;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_op();
    repeat (20) @(negedge clk);
    check(!busy, "R10", "no second operation", busy, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule